// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block sits on the host side of an asynchronous NAND flash device and turns one request into the cycle-level bus activity the device expects. A request carries a command byte, up to `ADDR_MAX` address bytes and an optional data phase, either write or read, of `req_len` words. The sequencer asserts chip enable for the whole transaction. It issues the command cycle with the command latch strobe high, then one address cycle per address byte with the address latch strobe high. It then waits for the device's ready/busy line before it moves any data.

The write and read strobes are timed by counters: each strobe is low for `T_LO` clocks and high for at least `T_HI` clocks between strobes. After the last command or address latch, and again after written data, the block waits at least `T_WB` clocks before it looks at ready/busy. This keeps a stale ready level from being taken for the device's answer. Write words come in over a valid/ready stream. Read words are taken on the rising edge of the read strobe and handed out over a valid/ready stream. A one-cycle `done` pulse marks the end of each transaction.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_io_oe`, `done` and `rd_valid` are low, and `req_ready` is high.
- R2: `nand_ce_n` goes low when a request is accepted and stays low until `done`. No strobe is ever low while `nand_ce_n` is high.
- R3: The first bus cycle of each transaction is a command cycle. At the rising edge of `nand_we_n`, `nand_cle`=1, `nand_ale`=0, `nand_io_oe`=1 and `nand_io_out` carries `req_cmd`.
- R4: Exactly `req_naddr` address cycles follow. At each `nand_we_n` rising edge, `nand_ale`=1, `nand_cle`=0 and `nand_io_oe`=1. The bytes go out least significant first: `req_addr[7:0]`, then `req_addr[15:8]`, and so on.
- R5: Each write or read strobe is low for exactly `T_LO` clocks. Both strobes stay high for at least `T_HI` clocks between strobes, and the two are never low together.
- R6: After the last command/address latch or the last write word, the block allows at least `T_WB` clocks before the next data strobe or `done`. Neither happens before `nand_rb` has been seen high (1 = ready).
- R7: Write data (`req_op`=2'b01) sends `req_len` words taken from the `wr_valid`/`wr_ready` stream in order. At each `nand_we_n` rise, `nand_cle`=`nand_ale`=0 and `nand_io_oe`=1. No write strobe starts while `wr_valid` is low.
- R8: Read data (`req_op`=2'b10) takes `req_len` words from `nand_io_in` at the rising edge of `nand_re_n`, with `nand_io_oe` low while `nand_re_n` is low. Each word is held on `rd_data` with `rd_valid` until `rd_ready`. No new read strobe starts while a word is pending.
- R9: `done` is a single-cycle pulse. It follows the busy wait for transactions that end with latches or writes, and the last read strobe for reads. `req_ready` stays low from acceptance until then.
- R10: `req_op` 2'b00 and 2'b11, and any data operation with `req_len`=0, skip the data phase, so the transaction has only command and address cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_cmd | input | 8 | Command byte |
| req_addr | input | ADDR_MAX*8 | Address bytes, byte 0 in bits 7:0 |
| req_naddr | input | $clog2(ADDR_MAX+1) | Number of address cycles |
| req_op | input | 2 | Data phase: 00 none, 01 write, 10 read, 11 none |
| req_len | input | LEN_W | Number of data words |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | IO_W | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes read word |
| rd_data | output | IO_W | Read word |
| done | output | 1 | End-of-transaction pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | IO_W | Bus value driven toward the device |
| nand_io_oe | output | 1 | Bus driver enable |
| nand_io_in | input | IO_W | Bus value seen from the device |
| nand_rb | input | 1 | Ready/busy, low while busy |

## Verification
The embedded assertions check several properties on every clock:
- strobe low width equals `T_LO`, and the two strobes never overlap;
- the latch enables are exclusive;
- chip enable covers every strobe, and the bus driver is released during reads;
- a pending read word stays steady;
- `done` lasts one cycle;
- the busy-wait exit sees a ready level only after the minimum wait.

Some behaviour only the bench scenarios can show. These are the order and values of command, address and data bytes on the bus, and that the latch kinds match the request. They also include stalls from a withheld write stream or a read consumer that is not ready, the skipping of data phases for the no-data encodings, and the gaps measured at the pins against a device model that holds busy low.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WAIT,
    ST_DATA
  } state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LO,
    PH_HI
  } phase_e;
endpackage

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nand_seq_pkg::*;
#(
  parameter int T_LO = 2,
  parameter int T_HI = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic use_re,
  output logic busy,
  output logic rise,
  output logic fin,
  output logic we_n,
  output logic re_n
);
  localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CW   = $clog2(TMAX + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;

  assign busy = (ph != PH_IDLE);
  assign rise = (ph == PH_LO) && (cnt == '0);
  assign fin  = (ph == PH_HI) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      we_n <= 1'b1;
      re_n <= 1'b1;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_LO;
          cnt  <= CW'(T_LO - 1);
          we_n <= use_re;
          re_n <= !use_re;
        end
        PH_LO: if (cnt == '0) begin
          ph   <= PH_HI;
          cnt  <= CW'(T_HI - 1);
          we_n <= 1'b1;
          re_n <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_HI: if (cnt == '0) ph <= PH_IDLE;
               else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic [CW:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst) lo_run <= '0;
    else if (!we_n || !re_n) lo_run <= lo_run + 1'b1;
    else lo_run <= '0;
  end

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(we_n) || $rose(re_n)) |-> (lo_run == (CW+1)'(T_LO)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int T_WB = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rb,
  output logic done
);
  localparam int CW = $clog2(T_WB + 1);

  logic [1:0]    sync;
  logic          rb_s;
  logic          active;
  logic [CW-1:0] cnt;

  assign rb_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= 2'b00;
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      sync <= {sync[0], rb};
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= CW'(T_WB);
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (rb_s) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  logic [CW:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (start) age <= '0;
    else if (active && (age != '1)) age <= age + 1'b1;
  end

  // R6
  rb_seen_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rb_s));

  // R6
  min_wait_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (age >= (CW+1)'(T_WB)));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int IO_W     = 8,
  parameter int ADDR_MAX = 5,
  parameter int LEN_W    = 12,
  parameter int T_LO     = 2,
  parameter int T_HI     = 2,
  parameter int T_WB     = 4,
  localparam int NA_W    = $clog2(ADDR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [7:0]            req_cmd,
  input  logic [ADDR_MAX*8-1:0] req_addr,
  input  logic [NA_W-1:0]       req_naddr,
  input  logic [1:0]            req_op,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [IO_W-1:0]       wr_data,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [IO_W-1:0]       rd_data,
  output logic                  done,
  output logic                  nand_ce_n,
  output logic                  nand_cle,
  output logic                  nand_ale,
  output logic                  nand_we_n,
  output logic                  nand_re_n,
  output logic [IO_W-1:0]       nand_io_out,
  output logic                  nand_io_oe,
  input  logic [IO_W-1:0]       nand_io_in,
  input  logic                  nand_rb
);
  state_e                state;
  op_e                   op_q;
  logic [7:0]            cmd_q;
  logic [ADDR_MAX*8-1:0] addr_q;
  logic [NA_W-1:0]       na_q;
  logic [LEN_W-1:0]      len_q;
  logic                  issued;
  logic                  data_pend;

  logic t_start, t_busy, t_rise, t_fin, w_start, w_done;
  logic is_rd, can_go, bus_state;

  assign is_rd     = (state == ST_DATA) && (op_q == OP_READ);
  assign bus_state = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA);

  always_comb begin
    can_go = 1'b1;
    if (state == ST_DATA) can_go = is_rd ? !rd_valid : wr_valid;
  end

  assign t_start   = bus_state && !issued && !t_busy && can_go;
  assign wr_ready  = t_start && (state == ST_DATA) && (op_q == OP_WRITE);
  assign w_start   = (state == ST_WAIT) && !issued;
  assign req_ready = (state == ST_IDLE);

  nand_strobe_timer #(.T_LO(T_LO), .T_HI(T_HI)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .use_re(is_rd),
    .busy(t_busy), .rise(t_rise), .fin(t_fin),
    .we_n(nand_we_n), .re_n(nand_re_n)
  );

  nand_rb_wait #(.T_WB(T_WB)) u_rbwait (
    .clk(clk), .rst(rst), .start(w_start), .rb(nand_rb), .done(w_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_NONE;
      cmd_q       <= '0;
      addr_q      <= '0;
      na_q        <= '0;
      len_q       <= '0;
      issued      <= 1'b0;
      data_pend   <= 1'b0;
      done        <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_io_oe  <= 1'b0;
      nand_io_out <= '0;
    end else begin
      done <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (t_rise && is_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= nand_io_in;
      end
      if (t_start) begin
        issued     <= 1'b1;
        nand_cle   <= (state == ST_CMD);
        nand_ale   <= (state == ST_ADDR);
        nand_io_oe <= !is_rd;
        case (state)
          ST_CMD:  nand_io_out <= IO_W'(cmd_q);
          ST_ADDR: nand_io_out <= IO_W'(addr_q[7:0]);
          default: nand_io_out <= is_rd ? nand_io_out : wr_data;
        endcase
      end
      if (w_start) issued <= 1'b1;
      if (t_fin) begin
        nand_cle   <= 1'b0;
        nand_ale   <= 1'b0;
        nand_io_oe <= 1'b0;
      end
      case (state)
        ST_IDLE: if (req_valid) begin
          cmd_q     <= req_cmd;
          addr_q    <= req_addr;
          na_q      <= req_naddr;
          op_q      <= op_e'(req_op);
          len_q     <= req_len;
          data_pend <= ((req_op == OP_WRITE) || (req_op == OP_READ)) && (req_len != '0);
          nand_ce_n <= 1'b0;
          state     <= ST_CMD;
        end
        ST_CMD: if (t_fin) begin
          issued <= 1'b0;
          state  <= (na_q != '0) ? ST_ADDR : ST_WAIT;
        end
        ST_ADDR: if (t_fin) begin
          issued <= 1'b0;
          addr_q <= addr_q >> 8;
          na_q   <= na_q - 1'b1;
          if (na_q == NA_W'(1)) state <= ST_WAIT;
        end
        ST_WAIT: if (w_done) begin
          issued <= 1'b0;
          if (data_pend) begin
            data_pend <= 1'b0;
            state     <= ST_DATA;
          end else begin
            state     <= ST_IDLE;
            nand_ce_n <= 1'b1;
            done      <= 1'b1;
          end
        end
        ST_DATA: if (t_fin) begin
          issued <= 1'b0;
          len_q  <= len_q - 1'b1;
          if (len_q == LEN_W'(1)) begin
            if (op_q == OP_WRITE) begin
              state <= ST_WAIT;
            end else begin
              state     <= ST_IDLE;
              nand_ce_n <= 1'b1;
              done      <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3 R4
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  // R2
  ce_covers_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    nand_ce_n |-> (nand_we_n && nand_re_n));

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_io_oe);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> nand_ce_n);
endmodule

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  localparam int IO_W = 8, ADDR_MAX = 5, LEN_W = 12;
  localparam int T_LO = 2, T_HI = 2, T_WB = 4;
  localparam int NA_W = $clog2(ADDR_MAX + 1);
  localparam logic [1:0] K_C = 2'd0, K_A = 2'd1, K_W = 2'd2;

  typedef struct packed { logic [1:0] kind; logic [7:0] val; } ev_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_cmd = '0;
  logic [ADDR_MAX*8-1:0] req_addr = '0;
  logic [NA_W-1:0] req_naddr = '0;
  logic [1:0] req_op = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [IO_W-1:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [IO_W-1:0] rd_data;
  logic done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [IO_W-1:0] nand_io_out, nand_io_in = '0;
  logic nand_rb = 1'b1;

  always #5 clk = ~clk;

  nand_bus_seq #(.IO_W(IO_W), .ADDR_MAX(ADDR_MAX), .LEN_W(LEN_W),
                 .T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB)) u_nand_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_naddr(req_naddr),
    .req_op(req_op), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  int tests = 0, fails = 0;
  ev_t bus_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] wr_src[$];
  int busy_len = 0, busy_cnt = 0, done_cnt = 0, dev_idx = 0, rd_mirror = 0, wr_seed = 0;
  bit wr_block = 1'b0;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37) ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // samples taken at the active edge with the pre-edge values
  logic s_rdv = 1'b0, s_wrv = 1'b0, hs_r = 1'b0, hs_w = 1'b0;
  logic [7:0] hs_rdata = '0;
  always @(posedge clk) begin
    s_rdv    <= rd_valid;
    s_wrv    <= wr_valid;
    hs_r     <= rd_valid && rd_ready;
    hs_w     <= wr_valid && wr_ready;
    hs_rdata <= rd_data;
  end

  // monitor and device model
  logic prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;
  int we_lo = 0, re_lo = 0, hi_cnt = 100, since = 100;
  logic [1:0] last_kind = 2'd3;
  always @(negedge clk) begin
    if (!rst) begin
      automatic bit we_rise = !prev_we && nand_we_n;
      automatic bit we_fall = prev_we && !nand_we_n;
      automatic bit re_rise = !prev_re && nand_re_n;
      automatic bit re_fall = prev_re && !nand_re_n;
      automatic bit latched = 1'b0;
      automatic ev_t got, exp;
      since++;
      if (!nand_we_n) we_lo++;
      if (!nand_re_n) re_lo++;
      if (!nand_we_n || !nand_re_n) check(!nand_ce_n, "R2 ce low during strobe", nand_ce_n, 0);
      if (!nand_ce_n) check(!req_ready, "R9 req_ready low in flight", req_ready, 0);
      if (we_fall || re_fall) check(hi_cnt >= T_HI, "R5 high gap", hi_cnt, T_HI);
      if (nand_we_n && nand_re_n) hi_cnt++; else hi_cnt = 0;
      if ((we_fall && !nand_cle && !nand_ale) || re_fall) begin
        if (last_kind == K_C || last_kind == K_A) begin
          check(since >= T_WB, "R6 wait before data", since, T_WB);
          check(nand_rb, "R6 data only when ready", nand_rb, 1);
        end
        if (re_fall) check(!s_rdv, "R8 no read while word pending", s_rdv, 0);
        else check(s_wrv, "R7 write only with wr_valid", s_wrv, 1);
      end
      if (!nand_re_n) check(!nand_io_oe, "R8 driver released in read", nand_io_oe, 0);
      if (we_rise) begin
        check(we_lo == T_LO, "R5 we low width", we_lo, T_LO);
        we_lo = 0;
        check(nand_io_oe, "R3 R4 R7 driver on at latch", nand_io_oe, 1);
        got.kind = nand_cle ? K_C : (nand_ale ? K_A : K_W);
        got.val  = nand_io_out;
        if (bus_q.size() == 0) begin
          check(1'b0, "R10 unexpected bus cycle", int'(got), 0);
        end else begin
          exp = bus_q.pop_front();
          check(got == exp, (exp.kind == K_C) ? "R3 command cycle" :
                (exp.kind == K_A) ? "R4 address cycle" : "R7 write cycle",
                int'(got), int'(exp));
        end
        last_kind = got.kind;
        since = 0;
        latched = 1'b1;
      end
      if (re_rise) begin
        check(re_lo == T_LO, "R5 re low width", re_lo, T_LO);
        re_lo = 0;
        dev_idx++;
        last_kind = 2'd3;
      end
      if (hs_r) begin
        if (rd_q.size() == 0) check(1'b0, "R8 unexpected read word", hs_rdata, 0);
        else begin
          exp.val = rd_q.pop_front();
          check(hs_rdata == exp.val, "R8 read word", hs_rdata, exp.val);
        end
      end
      if (hs_w && wr_src.size() > 0) void'(wr_src.pop_front());
      if (done) begin
        done_cnt++;
        check(!prev_done, "R9 done single pulse", prev_done, 0);
        if (last_kind != 2'd3) begin
          check(since >= T_WB, "R6 wait before done", since, T_WB);
          check(nand_rb, "R6 done only when ready", nand_rb, 1);
        end
      end
      if (latched) busy_cnt = busy_len;
      else if (busy_cnt > 0) busy_cnt--;
      nand_rb    = (busy_cnt == 0);
      nand_io_in = !nand_re_n ? pat(dev_idx) : 8'h00;
      wr_valid   = (wr_src.size() > 0) && !wr_block;
      wr_data    = (wr_src.size() > 0) ? wr_src[0] : 8'h00;
      prev_we = nand_we_n; prev_re = nand_re_n; prev_done = done;
    end
  end

  task automatic run_txn(input logic [7:0] c, input logic [39:0] a, input int na,
                         input logic [1:0] op, input int len, input int busy,
                         input bit stall_w, input int rd_hold);
    automatic bit has_data = ((op == 2'b01) || (op == 2'b10)) && (len > 0);
    automatic int d0;
    busy_len = busy;
    bus_q.push_back('{K_C, c});
    for (int i = 0; i < na; i++) bus_q.push_back('{K_A, a[8*i +: 8]});
    if (has_data && op == 2'b01) begin
      for (int i = 0; i < len; i++) begin
        wr_src.push_back(pat(wr_seed + 100 + i));
        bus_q.push_back('{K_W, pat(wr_seed + 100 + i)});
      end
      wr_seed += len;
    end
    if (has_data && op == 2'b10) begin
      for (int i = 0; i < len; i++) rd_q.push_back(pat(rd_mirror + i));
      rd_mirror += len;
    end
    wr_block = stall_w;
    rd_ready = (rd_hold == 0);
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_naddr = NA_W'(na);
    req_op = op; req_len = LEN_W'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (stall_w) begin
      repeat (30) @(negedge clk);
      wr_block = 1'b0;
    end
    if (rd_hold > 0) begin
      repeat (rd_hold) @(negedge clk);
      rd_ready = 1'b1;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(bus_q.size() == 0, "R9 all bus cycles issued", bus_q.size(), 0);
    check(rd_q.size() == 0, "R8 all read words delivered", rd_q.size(), 0);
    check(wr_src.size() == 0, "R7 all write words taken", wr_src.size(), 0);
    check(nand_ce_n && req_ready, "R2 idle after done", nand_ce_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high in reset", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches and driver off", {nand_cle, nand_ale, nand_io_oe}, 0);
    check(req_ready && !done && !rd_valid, "R1 idle handshake", {req_ready, done, rd_valid}, 4);
    // R3 command only
    run_txn(8'hFF, 40'h0, 0, 2'b00, 0, 10, 1'b0, 0);
    // R4 R8 three address bytes and a read
    run_txn(8'h00, 40'h00_0012_3456, 3, 2'b10, 4, 15, 1'b0, 0);
    // R7 five address bytes and a stalled write
    run_txn(8'h80, 40'h9A_BCDE_F011, 5, 2'b01, 3, 8, 1'b1, 0);
    // R8 read with consumer held off
    run_txn(8'h05, 40'h00_0000_7788, 2, 2'b10, 3, 5, 1'b0, 40);
    // R10 reserved op and zero-length read skip data
    run_txn(8'h60, 40'h00_0000_0042, 1, 2'b11, 4, 6, 1'b0, 0);
    run_txn(8'h30, 40'h00_0000_0043, 1, 2'b10, 0, 6, 1'b0, 0);
    // R6 device never busy: minimum wait alone gates the data phase
    run_txn(8'h10, 40'h00_0000_A5A5, 2, 2'b01, 2, 0, 1'b0, 0);
    run_txn(8'h11, 40'h00_0000_5A5A, 2, 2'b10, 2, 0, 1'b0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule